// File: doc/BRIEF.md
# Flat Page Table Walker

This block turns a 14-bit virtual address into a 12-bit physical address for a memory system built from 64-byte pages. A requester presents a virtual address together with the kind of access (read or write) and the privilege level (user or supervisor). The walker forms the address of one page table entry by adding the virtual page number to a table base held in an internal register. It issues exactly one read to page table memory and checks the returned entry. It then reports either the physical address or a fault code.

The table is flat: one entry per virtual page, 256 entries, with no further levels. Each entry carries a physical page number and four flag bits: present, supervisor-only, writable and readable. A missing entry and an access that breaks the flags produce two different fault codes. The result is held until the requester acknowledges it, and only then is a new request taken. The table base is loaded through a dedicated write port that only takes effect while the walker is idle.

Top module: `ptw_flat`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, `mem_req_valid` is 0, `res_valid` is 0, and the table base is 0.
- R2: For each accepted request, exactly one entry read is issued. Its address is (table base + VA[13:6]) modulo 2^MEM_AW, and `mem_req_valid` and `mem_req_addr` stay steady until `mem_req_ready` is seen.
- R3: When the entry permits the access, the result has fault code 2'b00 and physical address {PPN, VA[5:0]}. For example, VA 0x0020 with entry 0 holding PPN 0x28 gives 0xA20.
- R4: An entry is a 10-bit word laid out as bit 9 present, bit 8 supervisor-only, bit 7 writable, bit 6 readable, bits 5:0 physical page number.
- R5: An entry with the present bit at 0 gives fault code 2'b01 (not present) and physical address 0. For example, VA 0x0B8F (page 0x2E) with an absent entry faults.
- R6: A user-mode access to a present entry with the supervisor-only bit set gives fault code 2'b10 (protection) and physical address 0.
- R7: A write to a present entry without the writable bit, or a read from one without the readable bit, gives fault code 2'b10. An absent entry reports 2'b01 whatever its other bits are.
- R8: `res_valid`, `res_pa` and `res_fault` stay steady until `res_ack` is sampled high. The cycle after that, `res_valid` is 0 and `req_ready` is 1.
- R9: A base write while `req_ready` is 0 is dropped and has no effect on later walks. A base write while idle is used from the next walk on, including a request accepted in the same cycle.
- R10: A request is accepted only in a cycle where `req_ready` is 1. Requests presented while a walk is in progress are ignored, so at most one walk is ever in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_we | input | 1 | Table base write strobe |
| base_wdata | input | MEM_AW (10) | New table base |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and accepting a request |
| req_va | input | VA_W (14) | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Table memory accepts the read |
| mem_req_addr | output | MEM_AW (10) | Entry address |
| mem_rsp_valid | input | 1 | Entry read data present |
| mem_rsp_data | input | 10 | Entry word |
| res_valid | output | 1 | Translation result present |
| res_ack | input | 1 | Requester takes the result |
| res_pa | output | PA_W (12) | Physical address, 0 on a fault |
| res_fault | output | 2 | 00 none, 01 not present, 10 protection |

## Verification
The assertions assume that table memory returns data only after it has accepted a read, and at most once per accepted read. They also assume that `res_ack` is meaningful only while a result is shown. The bench's memory model keeps to this by answering one to three cycles after each accepted read and never otherwise. Its acceptance of reads is random, which exercises the hold rule. The bench also drives conflicting requests and base writes during walks, and acknowledges results after random delays, so the ignore and hold rules are checked against a behavioural model every cycle.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } ptw_state_e;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'b00,
        FLT_ABSENT = 2'b01,
        FLT_PROT   = 2'b10
    } ptw_fault_e;

    // Flag positions above the page number field, relative to its width
    localparam int FLAG_RD  = 0;
    localparam int FLAG_WR  = 1;
    localparam int FLAG_SUP = 2;
    localparam int FLAG_PRS = 3;
    localparam int FLAG_CNT = 4;

endpackage

// File: rtl/ptw_vsplit.sv
module ptw_vsplit #(
    parameter int VA_W     = 14,
    parameter int PG_OFF_W = 6,
    parameter int MEM_AW   = 10
) (
    input  logic [VA_W-1:0]     va_i,
    input  logic [MEM_AW-1:0]   base_i,
    output logic [PG_OFF_W-1:0] off_o,
    output logic [MEM_AW-1:0]   pte_addr_o
);
    localparam int VPN_W = VA_W - PG_OFF_W;

    logic [VPN_W-1:0] vpn;

    always_comb begin
        vpn        = va_i[VA_W-1:PG_OFF_W];
        off_o      = va_i[PG_OFF_W-1:0];
        // Wraps within the table memory address space
        pte_addr_o = base_i + MEM_AW'(vpn);
    end
endmodule

// File: rtl/ptw_perm.sv
module ptw_perm
    import ptw_pkg::*;
#(
    parameter int PPN_W = 6,
    localparam int PTE_W = PPN_W + FLAG_CNT
) (
    input  logic [PTE_W-1:0] pte_i,
    input  logic             is_write_i,
    input  logic             is_user_i,
    output ptw_fault_e       fault_o,
    output logic [PPN_W-1:0] ppn_o
);
    logic present, sup_only, can_wr, can_rd;

    always_comb begin
        present  = pte_i[PPN_W + FLAG_PRS];
        sup_only = pte_i[PPN_W + FLAG_SUP];
        can_wr   = pte_i[PPN_W + FLAG_WR];
        can_rd   = pte_i[PPN_W + FLAG_RD];
        ppn_o    = pte_i[PPN_W-1:0];

        // Absence outranks every permission failure
        if (!present)
            fault_o = FLT_ABSENT;
        else if (is_user_i && sup_only)
            fault_o = FLT_PROT;
        else if (is_write_i ? !can_wr : !can_rd)
            fault_o = FLT_PROT;
        else
            fault_o = FLT_NONE;
    end
endmodule

// File: rtl/ptw_flat.sv
module ptw_flat
    import ptw_pkg::*;
#(
    parameter int VA_W     = 14,
    parameter int PA_W     = 12,
    parameter int PG_OFF_W = 6,
    parameter int MEM_AW   = 10,
    localparam int PPN_W   = PA_W - PG_OFF_W,
    localparam int PTE_W   = PPN_W + FLAG_CNT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_we,
    input  logic [MEM_AW-1:0] base_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_va,
    input  logic              req_write,
    input  logic              req_user,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [MEM_AW-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_data,
    output logic              res_valid,
    input  logic              res_ack,
    output logic [PA_W-1:0]   res_pa,
    output logic [1:0]        res_fault
);
    typedef struct packed {
        ptw_state_e        state;
        logic [MEM_AW-1:0] base;
        logic [VA_W-1:0]   va;
        logic              wr;
        logic              user;
        logic [PA_W-1:0]   pa;
        ptw_fault_e        fault;
    } walk_s;

    localparam walk_s WALK_RST = '{
        state: ST_IDLE, base: '0, va: '0, wr: 1'b0,
        user: 1'b0, pa: '0, fault: FLT_NONE
    };

    walk_s walk_d, walk_q;

    logic [PG_OFF_W-1:0] off;
    logic [MEM_AW-1:0]   pte_addr;
    ptw_fault_e          chk_fault;
    logic [PPN_W-1:0]    chk_ppn;

    ptw_vsplit #(
        .VA_W    (VA_W),
        .PG_OFF_W(PG_OFF_W),
        .MEM_AW  (MEM_AW)
    ) u_split (
        .va_i      (walk_q.va),
        .base_i    (walk_q.base),
        .off_o     (off),
        .pte_addr_o(pte_addr)
    );

    ptw_perm #(
        .PPN_W(PPN_W)
    ) u_perm (
        .pte_i     (mem_rsp_data),
        .is_write_i(walk_q.wr),
        .is_user_i (walk_q.user),
        .fault_o   (chk_fault),
        .ppn_o     (chk_ppn)
    );

    always_comb begin
        walk_d = walk_q;
        unique case (walk_q.state)
            ST_IDLE: begin
                if (base_we)
                    walk_d.base = base_wdata;
                if (req_valid) begin
                    walk_d.va    = req_va;
                    walk_d.wr    = req_write;
                    walk_d.user  = req_user;
                    walk_d.state = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (mem_req_ready)
                    walk_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    walk_d.fault = chk_fault;
                    walk_d.pa    = (chk_fault == FLT_NONE) ? {chk_ppn, off} : '0;
                    walk_d.state = ST_DONE;
                end
            end
            ST_DONE: begin
                if (res_ack)
                    walk_d.state = ST_IDLE;
            end
            default: walk_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            walk_q <= WALK_RST;
        else
            walk_q <= walk_d;
    end

    always_comb begin
        req_ready     = (walk_q.state == ST_IDLE);
        mem_req_valid = (walk_q.state == ST_ISSUE);
        mem_req_addr  = pte_addr;
        res_valid     = (walk_q.state == ST_DONE);
        res_pa        = walk_q.pa;
        res_fault     = walk_q.fault;
    end
endmodule

// File: rtl/ptw_flat_chk.sv
module ptw_flat_chk #(
    parameter int PA_W   = 12,
    parameter int MEM_AW = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [MEM_AW-1:0] mem_req_addr,
    input logic              res_valid,
    input logic              res_ack,
    input logic [PA_W-1:0]   res_pa,
    input logic [1:0]        res_fault
);
    // R2: read request holds address until taken
    assert_mem_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R2: one read per walk, never a second one right after acceptance
    assert_single_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_ready |=> !mem_req_valid);

    // R8: result held until acknowledged
    assert_res_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_ack |=> res_valid && $stable(res_pa) && $stable(res_fault));

    // R8: acknowledge returns the walker to idle
    assert_ack_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_ack |=> req_ready && !res_valid);

    // R5: faulting result carries a zero address
    assert_fault_zero_pa_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && (res_fault != 2'b00) |-> res_pa == '0);

    // R7: only the three defined fault codes appear
    assert_fault_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> res_fault != 2'b11);

    // R10: idle, reading and reporting never overlap
    assert_one_walk_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_ready, mem_req_valid, res_valid}));
endmodule

bind ptw_flat ptw_flat_chk #(
    .PA_W  (PA_W),
    .MEM_AW(MEM_AW)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_ready    (req_ready),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_addr (mem_req_addr),
    .res_valid    (res_valid),
    .res_ack      (res_ack),
    .res_pa       (res_pa),
    .res_fault    (res_fault)
);

// File: tb/sim_ptw_flat.sv
`timescale 1ns/1ps
module sim_ptw_flat;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_we = 1'b0;
    logic [9:0]  base_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [13:0] req_va = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [9:0]  mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [9:0]  mem_rsp_data = '0;
    logic        res_valid;
    logic        res_ack = 1'b0;
    logic [11:0] res_pa;
    logic [1:0]  res_fault;

    always #5 clk = ~clk;

    ptw_flat u0 (
        .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
        .req_write(req_write), .req_user(req_user),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .res_valid(res_valid), .res_ack(res_ack),
        .res_pa(res_pa), .res_fault(res_fault)
    );

    int checks = 0;
    int failures = 0;

    logic [9:0] ptmem [0:1023];
    logic [9:0] tb_base = '0;

    // Behavioural model state
    int          m_state = 0;
    logic [9:0]  m_base = '0;
    logic [13:0] m_va = '0;
    logic        m_wr = 1'b0, m_user = 1'b0;
    logic [11:0] m_pa = '0;
    logic [1:0]  m_fault = '0;
    int          pend = 0;
    logic [9:0]  pend_addr = '0;

    function automatic logic [9:0] pte(input logic p, s, w, r, input logic [5:0] ppn);
        return {p, s, w, r, ppn};
    endfunction

    function automatic logic [1:0] ref_fault(input logic [9:0] e, input logic wr, user);
        if (!e[9]) return 2'b01;
        if (user && e[8]) return 2'b10;
        if (wr && !e[7]) return 2'b10;
        if (!wr && !e[6]) return 2'b10;
        return 2'b00;
    endfunction

    function automatic logic [11:0] ref_pa(input logic [9:0] e, input logic [13:0] va,
                                            input logic wr, user);
        if (ref_fault(e, wr, user) != 2'b00) return 12'h000;
        return {e[5:0], va[5:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One clock: bench memory, model step, edge, compare against model
    task automatic cycle();
        int          n_state = m_state;
        logic [9:0]  n_base = m_base;
        logic [13:0] n_va = m_va;
        logic        n_wr = m_wr, n_user = m_user;
        logic [11:0] n_pa = m_pa;
        logic [1:0]  n_fault = m_fault;
        int          n_pend = pend;
        logic [9:0]  n_paddr = pend_addr;
        logic [9:0]  e;
        mem_req_ready = ($urandom_range(0, 2) != 0);
        mem_rsp_valid = (pend == 1);
        mem_rsp_data  = (pend == 1) ? ptmem[pend_addr] : 10'h000;
        case (m_state)
            0: begin
                if (base_we) n_base = base_wdata;
                if (req_valid) begin
                    n_va = req_va; n_wr = req_write; n_user = req_user; n_state = 1;
                end
            end
            1: if (mem_req_ready) begin
                n_state = 2;
                n_pend  = int'($urandom_range(1, 3));
                n_paddr = m_base + 10'(m_va[13:6]);
            end
            2: if (mem_rsp_valid) begin
                e = mem_rsp_data;
                n_fault = ref_fault(e, m_wr, m_user);
                n_pa    = ref_pa(e, m_va, m_wr, m_user);
                n_state = 3;
            end
            default: if (res_ack) n_state = 0;
        endcase
        if (mem_rsp_valid) n_pend = 0;
        else if (pend > 1) n_pend = pend - 1;
        @(posedge clk);
        m_state = n_state; m_base = n_base; m_va = n_va; m_wr = n_wr; m_user = n_user;
        m_pa = n_pa; m_fault = n_fault; pend = n_pend; pend_addr = n_paddr;
        @(negedge clk);
        chk(req_ready == (m_state == 0), "R10", "req_ready", int'(req_ready), int'(m_state == 0));
        chk(mem_req_valid == (m_state == 1), "R2", "mem_req_valid", int'(mem_req_valid), int'(m_state == 1));
        if (m_state == 1)
            chk(mem_req_addr == m_base + 10'(m_va[13:6]), "R2", "mem_req_addr",
                int'(mem_req_addr), int'(m_base + 10'(m_va[13:6])));
        chk(res_valid == (m_state == 3), "R8", "res_valid", int'(res_valid), int'(m_state == 3));
        if (m_state == 3) begin
            chk(res_pa == m_pa, "R3", "res_pa", int'(res_pa), int'(m_pa));
            chk(res_fault == m_fault, "R5", "res_fault", int'(res_fault), int'(m_fault));
        end
    endtask

    task automatic set_base(input logic [9:0] v);
        base_we = 1'b1; base_wdata = v;
        cycle();
        base_we = 1'b0;
        tb_base = v;
    endtask

    task automatic xlate(input logic [13:0] va, input logic wr, user,
                         input logic [11:0] exp_pa, input logic [1:0] exp_f,
                         input string tag, input bit poke);
        logic [9:0] exp_addr = tb_base + 10'(va[13:6]);
        int k;
        req_valid = 1'b1; req_va = va; req_write = wr; req_user = user;
        cycle();
        req_valid = 1'b0;
        chk(mem_req_valid && mem_req_addr == exp_addr, "R2", "entry address",
            int'(mem_req_addr), int'(exp_addr));
        while (m_state != 3) begin
            if (poke) begin
                // R9 / R10: base write and a second request during the walk
                base_we = 1'b1; base_wdata = 10'h2AA;
                req_valid = 1'b1; req_va = 14'h3FFF; req_write = 1'b1; req_user = 1'b1;
            end
            cycle();
            base_we = 1'b0; req_valid = 1'b0;
        end
        chk(res_pa == exp_pa, tag, "result pa", int'(res_pa), int'(exp_pa));
        chk(res_fault == exp_f, tag, "result fault", int'(res_fault), int'(exp_f));
        k = int'($urandom_range(0, 3));
        for (int i = 0; i < k; i++) begin
            cycle();
            chk(res_valid && res_pa == exp_pa && res_fault == exp_f, "R8", "held result",
                int'(res_pa), int'(exp_pa));
        end
        res_ack = 1'b1;
        cycle();
        res_ack = 1'b0;
        chk(req_ready && !res_valid, "R8", "idle after ack", int'(req_ready), 1);
    endtask

    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) ptmem[i] = 10'h000;
        ptmem[10'h000] = pte(1, 0, 1, 1, 6'h28);
        ptmem[10'h005] = pte(1, 1, 1, 1, 6'h16);
        ptmem[10'h007] = pte(1, 0, 0, 1, 6'h11);
        ptmem[10'h008] = pte(1, 0, 1, 0, 6'h13);
        ptmem[10'h009] = pte(0, 1, 0, 0, 6'h3F);
        ptmem[10'h010] = pte(1, 0, 1, 1, 6'h3F);
        ptmem[10'h101] = pte(1, 0, 0, 1, 6'h2A);
        ptmem[10'h1FF] = pte(1, 0, 1, 1, 6'h01);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        chk(req_ready == 1'b1, "R1", "req_ready", int'(req_ready), 1);
        chk(mem_req_valid == 1'b0, "R1", "mem_req_valid", int'(mem_req_valid), 0);
        chk(res_valid == 1'b0, "R1", "res_valid", int'(res_valid), 0);

        xlate(14'h0020, 1'b0, 1'b0, 12'hA20, 2'b00, "R3", 1'b0);   // R4 field layout
        xlate(14'h0B8F, 1'b0, 1'b0, 12'h000, 2'b01, "R5", 1'b0);
        xlate(14'h0151, 1'b0, 1'b1, 12'h000, 2'b10, "R6", 1'b0);
        xlate(14'h0151, 1'b0, 1'b0, 12'h591, 2'b00, "R6", 1'b0);
        xlate(14'h01FF, 1'b1, 1'b0, 12'h000, 2'b10, "R7", 1'b0);
        xlate(14'h01FF, 1'b0, 1'b0, 12'h47F, 2'b00, "R4", 1'b0);
        xlate(14'h0200, 1'b0, 1'b0, 12'h000, 2'b10, "R7", 1'b0);
        xlate(14'h0200, 1'b1, 1'b1, 12'h4C0, 2'b00, "R4", 1'b0);
        xlate(14'h0240, 1'b1, 1'b1, 12'h000, 2'b01, "R7", 1'b0);
        set_base(10'h3F0);
        xlate(14'h0800, 1'b0, 1'b0, 12'hFC0, 2'b00, "R2", 1'b0);   // wraps to entry 0x010
        set_base(10'h100);
        xlate(14'h3FC1, 1'b0, 1'b0, 12'h041, 2'b00, "R9", 1'b1);   // poke during walk
        xlate(14'h0040, 1'b0, 1'b0, 12'hA80, 2'b00, "R9", 1'b0);   // old base still used
        // R9: base write accepted in the same cycle as a request
        base_we = 1'b1; base_wdata = 10'h3F0; tb_base = 10'h3F0;
        xlate(14'h0800, 1'b0, 1'b0, 12'hFC0, 2'b00, "R9", 1'b0);
        base_we = 1'b0;

        for (int i = 0; i < 1024; i++) ptmem[i] = 10'($urandom_range(0, 1023));
        for (int n = 0; n < 80; n++) begin
            logic [13:0] va = 14'($urandom_range(0, 16383));
            logic wr = 1'($urandom_range(0, 1));
            logic us = 1'($urandom_range(0, 1));
            logic [9:0] e;
            if (n % 10 == 0) set_base(10'($urandom_range(0, 1023)));
            e = ptmem[tb_base + 10'(va[13:6])];
            xlate(va, wr, us, ref_pa(e, va, wr, us), ref_fault(e, wr, us), "R7", n % 7 == 3);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule